// File: doc/BRIEF.md
# DDR Burst Write Mask Sequencer

This block sits between a 32-bit logical memory request port and a 16-bit DDR2-style data path whose bursts are always four beats long and can never be shortened. Each logical word occupies two neighbouring physical halfword locations. The less significant half sits at the lower physical address. A burst therefore holds two logical words, called the low slot (beats 1-2) and the high slot (beats 3-4). The block turns each accepted request into one or two such bursts. On writes it drives a per-beat data mask so that the beats carrying no requested data leave memory untouched.

A request is either single (one word at `req_addr`) or paired (words at `req_addr` and `req_addr+1`). A paired request at an even address fills one burst completely. A paired request at an odd address straddles two bursts, so it is issued as two half-used bursts and keeps the request port busy twice as long. Reads always take in all four beats of each burst and keep only the slot or slots that were asked for.

The controller is a six-state machine:
- `ST_IDLE` is the only state that accepts a request.
  - A write goes to `ST_WR_BEAT`.
  - A read goes to `ST_RD_CMD`.
- `ST_WR_BEAT` drives four beats.
  - After the fourth beat it either starts the second burst in the same state or returns to idle.
- `ST_RD_CMD` issues a one-cycle read command and moves on to `ST_RD_WAIT`.
- `ST_RD_WAIT` counts four returned beats and then moves to `ST_RD_TAKE`.
- `ST_RD_TAKE` copies the wanted slots into the response registers.
  - If a second burst is pending, it goes back to `ST_RD_CMD`.
  - Otherwise it goes to `ST_RESP`.
- `ST_RESP` presents the response for one cycle and returns to idle.

Top module: `ddr_burst_mask_seq`

## Requirements
- R1: Every write burst is exactly four consecutive `mem_wvalid` cycles. `mem_wfirst` is high on the first of these cycles only, and `mem_addr` holds the burst start address for all four.
- R2: The burst start address is `{req_addr[LADDR_W-1:1], 2'b00}`, so its two low bits are zero. A word at an even logical address uses beats 1-2 of that burst, and a word at an odd address uses beats 3-4. The first beat of a word carries bits 15:0 and the second beat carries bits 31:16.
- R3: A single write at an even address drives `mem_dm` = 00,00,11,11 over its four beats. At an odd address it drives 11,11,00,00. A `mem_dm` value of 11 means the beat is masked and 00 means it is written.
- R4: A paired write at an even address issues one burst with `mem_dm` = 00 on all four beats. `req_wdata0` goes on beats 1-2 and `req_wdata1` on beats 3-4.
- R5: A paired write at odd address A issues two bursts.
  - The first starts at `{A[LADDR_W-1:1],2'b00}` and carries `req_wdata0` on beats 3-4, with mask 11,11,00,00.
  - The second starts four halfwords higher and carries `req_wdata1` on beats 1-2, with mask 00,00,11,11.
- R6: `req_ready` is high only in idle. After a write handshake it stays low for exactly 4 cycles per burst.
- R7: A read issues one `mem_rcmd` per burst and consumes four `mem_rvalid` beats per burst. It then pulses `rsp_valid` for exactly one cycle. For a single read, `rsp_data0` is `{beat 2, beat 1}` at an even address or `{beat 4, beat 3}` at an odd address, and `rsp_data1` is zero.
- R8: A paired read returns the word at the request address on `rsp_data0` and the next word on `rsp_data1`. At an odd address it issues two read bursts, four halfwords apart. After a read handshake `req_ready` stays low for 6 cycles per burst plus one.
- R9: Both `mem_dm` bits always carry the same value. `mem_dm` is 00 whenever no write beat is being driven, including throughout reads.
- R10: After reset `req_ready` is 1, and `mem_wvalid`, `mem_rcmd` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pair | input | 1 | 1 = paired (two words), 0 = single word |
| req_addr | input | LADDR_W | Logical word address |
| req_wdata0 | input | 32 | Word for `req_addr` |
| req_wdata1 | input | 32 | Word for `req_addr+1` (paired only) |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data0 | output | 32 | Read word at `req_addr` |
| rsp_data1 | output | 32 | Read word at `req_addr+1`, zero for single reads |
| mem_addr | output | LADDR_W+1 | Physical burst start halfword address |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wfirst | output | 1 | First beat of a write burst |
| mem_wdata | output | 16 | Write beat data |
| mem_dm | output | 2 | Per-lane data mask, 1 = masked |
| mem_rcmd | output | 1 | Read burst command, one cycle |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 16 | Read beat data |

## Verification
A wrong beat counter or second-burst flag shows up at once as a misplaced `mem_wfirst`, a mask pattern shifted by one or more beats, or a busy time on `req_ready` other than 4 or 8 cycles. These symptoms appear on the write being issued. A wrong slot plan writes halfwords into the wrong physical locations. It is caught as soon as the bench compares its memory image with the reference image after the transaction ends. A read gather or slot-selection fault appears on the very next `rsp_valid` pulse as a swapped or wrong word. Directed corner cases cover both parities in both modes, and seeded random traffic then exercises mixed sequences.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_BEAT,
        ST_RD_CMD,
        ST_RD_WAIT,
        ST_RD_TAKE,
        ST_RESP
    } seq_state_t;

    localparam int BURST_BEATS = 4;
    localparam int SLOTS       = 2;

endpackage

// File: rtl/ddrseq_slot_plan.sv
// Decides which request word occupies each slot of the current burst
// and whether that slot is used at all.
module ddrseq_slot_plan (
    input  logic       pair,
    input  logic       addr_odd,
    input  logic       second,
    output logic [1:0] slot_en,
    output logic [1:0] slot_word
);
    always_comb begin
        slot_en   = 2'b00;
        slot_word = 2'b00;
        if (!pair) begin
            slot_en[addr_odd] = 1'b1;
        end else if (!addr_odd) begin
            slot_en   = 2'b11;
            slot_word = 2'b10;
        end else if (!second) begin
            slot_en   = 2'b10;
            slot_word = 2'b00;
        end else begin
            slot_en   = 2'b01;
            slot_word = 2'b01;
        end
    end
endmodule

// File: rtl/ddrseq_wr_beat.sv
// Selects the halfword and mask for one write beat.
module ddrseq_wr_beat #(
    parameter int BEAT_W = 16,
    parameter int MASK_W = 2
) (
    input  logic                active,
    input  logic [1:0]          beat,
    input  logic [2*BEAT_W-1:0] word0,
    input  logic [2*BEAT_W-1:0] word1,
    input  logic [1:0]          slot_en,
    input  logic [1:0]          slot_word,
    output logic [BEAT_W-1:0]   beat_data,
    output logic [MASK_W-1:0]   beat_mask
);
    localparam int WORD_W = 2 * BEAT_W;

    logic              slot;
    logic              used;
    logic [WORD_W-1:0] word;

    always_comb begin
        slot = beat[1];
        used = active && slot_en[slot];
        word = slot_word[slot] ? word1 : word0;
        if (!used)
            beat_data = '0;
        else if (beat[0])
            beat_data = word[WORD_W-1:BEAT_W];
        else
            beat_data = word[BEAT_W-1:0];
    end

    for (genvar g = 0; g < MASK_W; g++) begin : g_lane
        assign beat_mask[g] = active && !slot_en[slot];
    end
endmodule

// File: rtl/ddrseq_rd_gather.sv
// Collects the four beats of a read burst and presents them as slot words.
module ddrseq_rd_gather #(
    parameter int BEAT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                take,
    input  logic [BEAT_W-1:0]   beat_data,
    output logic                last_beat,
    output logic [2*BEAT_W-1:0] slot_data [2]
);
    logic [BEAT_W-1:0] beats_q [4];
    logic [1:0]        cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < 4; i++) beats_q[i] <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (take) begin
            beats_q[cnt_q] <= beat_data;
            cnt_q          <= cnt_q + 2'd1;
        end
    end

    assign last_beat = take && (cnt_q == 2'd3);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        assign slot_data[s] = {beats_q[2*s+1], beats_q[2*s]};
    end
endmodule

// File: rtl/ddr_burst_mask_seq.sv
module ddr_burst_mask_seq
    import ddrseq_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int BEAT_W  = 16,
    parameter int MASK_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_pair,
    input  logic [LADDR_W-1:0]   req_addr,
    input  logic [2*BEAT_W-1:0]  req_wdata0,
    input  logic [2*BEAT_W-1:0]  req_wdata1,
    output logic                 rsp_valid,
    output logic [2*BEAT_W-1:0]  rsp_data0,
    output logic [2*BEAT_W-1:0]  rsp_data1,
    output logic [LADDR_W:0]     mem_addr,
    output logic                 mem_wvalid,
    output logic                 mem_wfirst,
    output logic [BEAT_W-1:0]    mem_wdata,
    output logic [MASK_W-1:0]    mem_dm,
    output logic                 mem_rcmd,
    input  logic                 mem_rvalid,
    input  logic [BEAT_W-1:0]    mem_rdata
);
    localparam int WORD_W  = 2 * BEAT_W;
    localparam int PADDR_W = LADDR_W + 1;

    seq_state_t           state_q, state_d;
    logic                 op_write_q, op_pair_q, second_q;
    logic [LADDR_W-1:0]   op_addr_q;
    logic [WORD_W-1:0]    op_w0_q, op_w1_q;
    logic [1:0]           beat_q;
    logic [WORD_W-1:0]    rsp0_q, rsp1_q;

    logic                 split;
    logic [LADDR_W-2:0]   pair_idx;
    logic [PADDR_W-1:0]   burst_base;
    logic [1:0]           slot_en, slot_word;
    logic                 rd_last;
    logic [WORD_W-1:0]    rd_slot [2];
    logic                 wr_active;

    assign split     = op_pair_q && op_addr_q[0];
    assign pair_idx  = op_addr_q[LADDR_W-1:1] + {{(LADDR_W-2){1'b0}}, second_q};
    assign burst_base = {pair_idx, 2'b00};
    assign wr_active = (state_q == ST_WR_BEAT);

    ddrseq_slot_plan u_plan (
        .pair      (op_pair_q),
        .addr_odd  (op_addr_q[0]),
        .second    (second_q),
        .slot_en   (slot_en),
        .slot_word (slot_word)
    );

    ddrseq_wr_beat #(.BEAT_W(BEAT_W), .MASK_W(MASK_W)) u_wbeat (
        .active    (wr_active),
        .beat      (beat_q),
        .word0     (op_w0_q),
        .word1     (op_w1_q),
        .slot_en   (slot_en),
        .slot_word (slot_word),
        .beat_data (mem_wdata),
        .beat_mask (mem_dm)
    );

    ddrseq_rd_gather #(.BEAT_W(BEAT_W)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_RD_CMD),
        .take      ((state_q == ST_RD_WAIT) && mem_rvalid),
        .beat_data (mem_rdata),
        .last_beat (rd_last),
        .slot_data (rd_slot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (req_valid) state_d = req_write ? ST_WR_BEAT : ST_RD_CMD;
            ST_WR_BEAT:
                if (beat_q == 2'd3) state_d = (split && !second_q) ? ST_WR_BEAT : ST_IDLE;
            ST_RD_CMD:
                state_d = ST_RD_WAIT;
            ST_RD_WAIT:
                if (rd_last) state_d = ST_RD_TAKE;
            ST_RD_TAKE:
                state_d = (split && !second_q) ? ST_RD_CMD : ST_RESP;
            ST_RESP:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // request capture, beat counter and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write_q <= 1'b0;
            op_pair_q  <= 1'b0;
            op_addr_q  <= '0;
            op_w0_q    <= '0;
            op_w1_q    <= '0;
            beat_q     <= '0;
            second_q   <= 1'b0;
            rsp0_q     <= '0;
            rsp1_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_write_q <= req_write;
                    op_pair_q  <= req_pair;
                    op_addr_q  <= req_addr;
                    op_w0_q    <= req_wdata0;
                    op_w1_q    <= req_wdata1;
                    beat_q     <= '0;
                    second_q   <= 1'b0;
                    rsp0_q     <= '0;
                    rsp1_q     <= '0;
                end
                ST_WR_BEAT: begin
                    beat_q <= beat_q + 2'd1;
                    if (beat_q == 2'd3 && split) second_q <= 1'b1;
                end
                ST_RD_TAKE: begin
                    for (int s = 0; s < 2; s++) begin
                        if (slot_en[s]) begin
                            if (slot_word[s]) rsp1_q <= rd_slot[s];
                            else              rsp0_q <= rd_slot[s];
                        end
                    end
                    if (split) second_q <= 1'b1;
                end
                ST_RD_CMD, ST_RD_WAIT, ST_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_wvalid = wr_active;
        mem_wfirst = wr_active && (beat_q == 2'd0);
        mem_rcmd   = (state_q == ST_RD_CMD);
        rsp_valid  = (state_q == ST_RESP);
        mem_addr   = (wr_active || mem_rcmd) ? burst_base : '0;
        rsp_data0  = rsp0_q;
        rsp_data1  = rsp1_q;
    end

    // assertions
    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wfirst) |-> $stable(mem_addr));
    assert_first_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wvalid) |-> mem_wfirst);
    assert_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid || mem_rcmd) |-> (mem_addr[1:0] == 2'b00));
    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid || mem_rcmd) |-> !req_ready);
    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wvalid |-> (mem_dm == '0));
    assert_lanes_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dm == '0) || (mem_dm == '1));
endmodule

// File: tb/ddr_burst_mask_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_burst_mask_seq_tb_top;
    localparam int LADDR_W = 16;
    localparam int CLK_NS  = 20;
    localparam int MEMSZ   = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_pair = 1'b0;
    logic        req_ready;
    logic [LADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata0 = '0, req_wdata1 = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data0, rsp_data1;
    logic [LADDR_W:0] mem_addr;
    logic        mem_wvalid, mem_wfirst, mem_rcmd;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_dm;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    ddr_burst_mask_seq #(.LADDR_W(LADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_pair(req_pair), .req_addr(req_addr),
        .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
        .rsp_valid(rsp_valid), .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
        .mem_addr(mem_addr), .mem_wvalid(mem_wvalid), .mem_wfirst(mem_wfirst),
        .mem_wdata(mem_wdata), .mem_dm(mem_dm), .mem_rcmd(mem_rcmd),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [15:0] ref_mem [MEMSZ];
    logic [15:0] obs_mem [MEMSZ];

    // monitor / read responder state
    int          wn, wb, rcmd_n, rsp_n, rd_left, bad_first, bad_idle_dm, bad_lane;
    logic [1:0]  wlog_dm [8];
    int          wlog_addr [2];
    int          rlog_addr [2];
    int          raddr;
    logic [31:0] got0, got1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mem_wvalid) begin
            if (mem_wfirst) begin
                wb = 0;
                if (wn / 4 < 2) wlog_addr[wn/4] = int'(mem_addr);
            end else if (wn % 4 == 0) bad_first++;
            if (wn < 8) wlog_dm[wn] = mem_dm;
            if (mem_dm[0] != mem_dm[1]) bad_lane++;
            if (mem_dm == 2'b00) obs_mem[(int'(mem_addr) + wb) % MEMSZ] = mem_wdata;
            wb++;
            wn++;
        end else if (mem_dm != 2'b00) bad_idle_dm++;
        if (rd_left > 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = obs_mem[(raddr + 4 - rd_left) % MEMSZ];
            rd_left--;
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = 16'hDEAD;
        end
        if (mem_rcmd) begin
            if (rcmd_n < 2) rlog_addr[rcmd_n] = int'(mem_addr);
            rcmd_n++;
            raddr   = int'(mem_addr);
            rd_left = 4;
        end
        if (rsp_valid) begin
            rsp_n++;
            got0 = rsp_data0;
            got1 = rsp_data1;
        end
    end

    function automatic bit exp_mask(bit pair, bit odd, int k);
        if (!pair)     return odd ? (k < 2) : (k >= 2);
        else if (!odd) return 1'b0;
        else           return (k < 2) || (k >= 6);
    endfunction

    function automatic logic [31:0] ref_word(int a);
        return {ref_mem[(2*a+1) % MEMSZ], ref_mem[(2*a) % MEMSZ]};
    endfunction

    task automatic ref_store(int a, logic [31:0] w);
        ref_mem[(2*a) % MEMSZ]   = w[15:0];
        ref_mem[(2*a+1) % MEMSZ] = w[31:16];
    endtask

    task automatic do_req(input bit wr, input bit pr, input int a,
                          input logic [31:0] w0, input logic [31:0] w1);
        int busy, nb, mism, first_bad;
        bit odd;
        odd = a[0];
        nb  = (pr && odd) ? 2 : 1;
        @(negedge clk);
        wn = 0; rcmd_n = 0; rsp_n = 0; bad_first = 0; bad_idle_dm = 0; bad_lane = 0;
        req_valid = 1'b1; req_write = wr; req_pair = pr;
        req_addr = LADDR_W'(a); req_wdata0 = w0; req_wdata1 = w1;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready && busy < 100) begin
            busy++;
            @(negedge clk);
        end
        if (wr) begin
            ref_store(a, w0);
            if (pr) ref_store(a + 1, w1);
            chk(busy == 4*nb, "R6 write busy cycles", busy, 4*nb);
            chk(wn == 4*nb, "R1 write beat count", wn, 4*nb);
            chk(bad_first == 0, "R1 first-beat marker", bad_first, 0);
            chk(wlog_addr[0] == (a/2)*4, "R2 burst start address", wlog_addr[0], (a/2)*4);
            if (nb == 2)
                chk(wlog_addr[1] == (a/2)*4 + 4, "R5 second burst address", wlog_addr[1], (a/2)*4 + 4);
            for (int k = 0; k < 4*nb && k < 8; k++) begin
                logic [1:0] e;
                e = exp_mask(pr, odd, k) ? 2'b11 : 2'b00;
                if (!pr) chk(wlog_dm[k] == e, "R3 single write mask", wlog_dm[k], e);
                else if (!odd) chk(wlog_dm[k] == e, "R4 paired even mask", wlog_dm[k], e);
                else chk(wlog_dm[k] == e, "R5 paired odd mask", wlog_dm[k], e);
            end
            mism = 0; first_bad = -1;
            for (int i = 0; i < MEMSZ; i++)
                if (obs_mem[i] !== ref_mem[i]) begin
                    mism++;
                    if (first_bad < 0) first_bad = i;
                end
            if (first_bad < 0) first_bad = 0;
            chk(mism == 0, "R2 memory image after write", obs_mem[first_bad], ref_mem[first_bad]);
        end else begin
            chk(busy == 6*nb + 1, "R8 read busy cycles", busy, 6*nb + 1);
            chk(rcmd_n == nb, "R7 read command count", rcmd_n, nb);
            chk(rlog_addr[0] == (a/2)*4, "R7 read burst address", rlog_addr[0], (a/2)*4);
            if (nb == 2)
                chk(rlog_addr[1] == (a/2)*4 + 4, "R8 second read address", rlog_addr[1], (a/2)*4 + 4);
            chk(rsp_n == 1, "R7 response pulse count", rsp_n, 1);
            chk(got0 == ref_word(a), "R7 read word 0", got0, ref_word(a));
            if (pr) chk(got1 == ref_word(a + 1), "R8 read word 1", got1, ref_word(a + 1));
            else    chk(got1 == 32'h0, "R7 single read word 1 zero", got1, 0);
            chk(wn == 0, "R9 no write beats on read", wn, 0);
        end
        chk(bad_idle_dm == 0, "R9 mask quiet off write beats", bad_idle_dm, 0);
        chk(bad_lane == 0, "R9 mask lanes equal", bad_lane, 0);
    endtask

    initial begin
        int seed;
        for (int i = 0; i < MEMSZ; i++) begin
            ref_mem[i] = 16'(i * 16'h1357) ^ 16'hA5A5;
            obs_mem[i] = ref_mem[i];
        end
        rd_left = 0;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
        chk(!mem_wvalid && !mem_rcmd && !rsp_valid, "R10 outputs idle in reset",
            {mem_wvalid, mem_rcmd, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);

        // directed corners
        do_req(1, 0, 10, 32'h1111_2222, 32'h0);          // R3 even
        do_req(1, 0, 13, 32'h3333_4444, 32'h0);          // R3 odd
        do_req(1, 1, 20, 32'h5555_6666, 32'h7777_8888);  // R4
        do_req(1, 1, 25, 32'h9999_AAAA, 32'hBBBB_CCCC);  // R5
        do_req(0, 0, 10, 0, 0);                          // R7 even
        do_req(0, 0, 13, 0, 0);                          // R7 odd
        do_req(0, 1, 20, 0, 0);                          // R8 even
        do_req(0, 1, 25, 0, 0);                          // R8 odd
        do_req(0, 1, 11, 0, 0);                          // R8 across neighbours

        // seeded random mix
        for (int t = 0; t < 300; t++) begin
            do_req(1'($urandom), 1'($urandom), int'($urandom % 120), $urandom, $urandom);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule